// File: doc/BRIEF.md
# Fault Status Latch and Recovery Manager

This block keeps the diagnostic status word of a two-channel supply and carries out its recovery policy after a fault. It receives four live fault conditions from the analog side: overtemperature, overcurrent on channel A, overcurrent on channel B, and input power not good. Each condition passes through a synchronizer chain and then sets a sticky status bit.

A status bit goes low again only once its cause is gone and a status read happens after that. The block drives an active-low fault pin from the status word. It also shuts the step-up stage and the output channels off while a thermal or overcurrent cause is present.

Two policy inputs choose what happens to each channel's voltage-select setting when a fault begins. The setting is either wiped, through a one-cycle clear request to the register file, or kept so that the output returns by itself. An undervoltage-lockout input holds everything at zero.

Top module: `fault_recovery_mgr`

## Requirements
- R1: While `uvlo_i` is high, and after reset, `status_o` is 0, `fault_n_o` is 1, and `vsel_clr_o`, `boost_off_o` and `chan_off_o` are 0. These values take effect one clock edge after `uvlo_i` is sampled high.
- R2: A fault input held high sets its status bit SYNC_STAGES+1 rising edges later. The bit positions are: bit 0 overtemperature, bit 1 overcurrent A, bit 2 overcurrent B, bit 3 power not good.
- R3: A set status bit stays high after its cause drops, for as long as no status read is made.
- R4: A read strobe sampled while a bit's synchronized cause is still high leaves that bit set. A read sampled after the cause has dropped clears that bit at that edge. Bits whose causes remain are left set.
- R5: `fault_n_o` is low exactly when at least one bit of `status_o` is high.
- R6: `boost_off_o` follows the synchronized overtemperature cause. `chan_off_o[0]` follows overtemperature OR overcurrent A, and `chan_off_o[1]` follows overtemperature OR overcurrent B. Each output sets and releases SYNC_STAGES+1 edges after its input changes, whatever the state of the latched status bits.
- R7: With `therm_wipe_i`=1, the onset of overtemperature raises `vsel_clr_o`=2'b11 for exactly one cycle, at the same edge that sets status bit 0. With `therm_wipe_i`=0, overtemperature raises no clear request.
- R8: With `ovl_wipe_i`=1, the onset of overcurrent A raises `vsel_clr_o[0]`, and the onset of overcurrent B raises `vsel_clr_o[1]`, each for one cycle. With `ovl_wipe_i`=0, overcurrent raises no clear request.
- R9: No clear request is raised while `uvlo_i` is high. No clear request is raised on release of `uvlo_i` for a cause that was already present during lockout. Such a cause sets its status bit again one edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uvlo_i | input | 1 | Undervoltage lockout, forces all state low |
| rd_stb_i | input | 1 | One-cycle status register read strobe |
| hot_i | input | 1 | Live overtemperature condition |
| ovl_a_i | input | 1 | Live overcurrent condition, channel A |
| ovl_b_i | input | 1 | Live overcurrent condition, channel B |
| png_i | input | 1 | Live input power not good condition |
| therm_wipe_i | input | 1 | 1: thermal fault wipes both voltage-select fields |
| ovl_wipe_i | input | 1 | 1: overcurrent wipes that channel's voltage-select field |
| status_o | output | 4 | Sticky diagnostic bits {png, ovl_b, ovl_a, hot} |
| fault_n_o | output | 1 | Active-low fault pin |
| vsel_clr_o | output | 2 | One-cycle clear request per channel (bit 0 = A) |
| boost_off_o | output | 1 | Step-up stage shutdown |
| chan_off_o | output | 2 | Per-channel output shutdown (bit 0 = A) |

## Verification
Two events can meet in one cycle: a status read, and the drop or persistence of a fault's cause. The bench sweeps every pair of a set pattern and a remaining-cause pattern under all four policy settings. In each case it lets the dropped causes clear the synchronizer, then issues a single read, and expects exactly the bits whose cause remains. A read issued while every cause is still present must change nothing. Lockout is also applied together with fault onsets, and the bench judges whether clear requests stay suppressed, both during lockout and on its release.

// File: rtl/fault_mgr_pkg.sv
package fault_mgr_pkg;

    localparam int NUM_DIAG = 4;
    localparam int NUM_CH   = 2;

    // bit order is the status word layout seen by the register file
    typedef struct packed {
        logic png;
        logic ovl_b;
        logic ovl_a;
        logic hot;
    } diag_t;

    typedef enum logic [1:0] {
        IDX_HOT  = 2'd0,
        IDX_OVLA = 2'd1,
        IDX_OVLB = 2'd2,
        IDX_PNG  = 2'd3
    } diag_idx_e;

    // which channels lose their voltage setting for a given set of new faults
    function automatic logic [NUM_CH-1:0] wipe_mask(
        input diag_t onset,
        input logic  therm_wipe,
        input logic  ovl_wipe
    );
        logic [NUM_CH-1:0] m;
        m = {NUM_CH{therm_wipe & onset.hot}};
        m = m | ({onset.ovl_b, onset.ovl_a} & {NUM_CH{ovl_wipe}});
        return m;
    endfunction

    // which output channels are held off by live causes
    function automatic logic [NUM_CH-1:0] off_mask(input diag_t live);
        return {live.ovl_b | live.hot, live.ovl_a | live.hot};
    endfunction

endpackage

// File: rtl/fmgr_sync.sv
module fmgr_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    generate
        if (STAGES == 0) begin : g_pass
            assign q_o = d_i;
        end else begin : g_chain
            logic [WIDTH-1:0] stage_q [STAGES];
            for (genvar s = 0; s < STAGES; s++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (rst) begin
                        stage_q[s] <= '0;
                    end else if (s == 0) begin
                        stage_q[s] <= d_i;
                    end else begin
                        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                    end
                end
            end
            assign q_o = stage_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/fmgr_diag_cell.sv
module fmgr_diag_cell (
    input  logic clk,
    input  logic rst,
    input  logic uvlo_i,
    input  logic rd_i,
    input  logic cause_i,
    output logic flag_o
);
    logic flag_q;
    logic release_ok;

    // a read only clears when the cause is already gone at that edge
    assign release_ok = rd_i & ~cause_i;

    always_ff @(posedge clk) begin
        if (rst || uvlo_i) begin
            flag_q <= 1'b0;
        end else if (cause_i) begin
            flag_q <= 1'b1;
        end else if (release_ok) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/fmgr_policy.sv
module fmgr_policy
    import fault_mgr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              uvlo_i,
    input  diag_t             live_i,
    input  logic              therm_wipe_i,
    input  logic              ovl_wipe_i,
    output logic [NUM_CH-1:0] clr_o,
    output logic              boost_off_o,
    output logic [NUM_CH-1:0] chan_off_o
);
    diag_t             live_q;
    diag_t             onset;
    logic [NUM_CH-1:0] clr_q;
    logic [NUM_CH-1:0] off_q;
    logic              boost_q;

    assign onset = live_i & ~live_q;

    // edge history runs through lockout so release brings no false onset
    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
        end else begin
            live_q <= live_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || uvlo_i) begin
            clr_q   <= '0;
            off_q   <= '0;
            boost_q <= 1'b0;
        end else begin
            clr_q   <= wipe_mask(onset, therm_wipe_i, ovl_wipe_i);
            off_q   <= off_mask(live_i);
            boost_q <= live_i.hot;
        end
    end

    assign clr_o       = clr_q;
    assign chan_off_o  = off_q;
    assign boost_off_o = boost_q;
endmodule

// File: rtl/fault_recovery_mgr.sv
module fault_recovery_mgr
    import fault_mgr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        uvlo_i,
    input  logic        rd_stb_i,
    input  logic        hot_i,
    input  logic        ovl_a_i,
    input  logic        ovl_b_i,
    input  logic        png_i,
    input  logic        therm_wipe_i,
    input  logic        ovl_wipe_i,
    output logic [3:0]  status_o,
    output logic        fault_n_o,
    output logic [1:0]  vsel_clr_o,
    output logic        boost_off_o,
    output logic [1:0]  chan_off_o
);
    diag_t                raw;
    logic [NUM_DIAG-1:0]  cond_s;
    logic [NUM_DIAG-1:0]  flags;

    assign raw = '{png: png_i, ovl_b: ovl_b_i, ovl_a: ovl_a_i, hot: hot_i};

    fmgr_sync #(.WIDTH(NUM_DIAG), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw),
        .q_o (cond_s)
    );

    for (genvar i = 0; i < NUM_DIAG; i++) begin : g_cell
        fmgr_diag_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .uvlo_i  (uvlo_i),
            .rd_i    (rd_stb_i),
            .cause_i (cond_s[i]),
            .flag_o  (flags[i])
        );
    end

    fmgr_policy u_policy (
        .clk          (clk),
        .rst          (rst),
        .uvlo_i       (uvlo_i),
        .live_i       (diag_t'(cond_s)),
        .therm_wipe_i (therm_wipe_i),
        .ovl_wipe_i   (ovl_wipe_i),
        .clr_o        (vsel_clr_o),
        .boost_off_o  (boost_off_o),
        .chan_off_o   (chan_off_o)
    );

    assign status_o  = flags;
    assign fault_n_o = ~(|flags);
endmodule

// File: rtl/fault_recovery_mgr_chk.sv
module fault_recovery_mgr_chk (
    input logic       clk,
    input logic       rst,
    input logic       uvlo_i,
    input logic       rd_stb_i,
    input logic [3:0] cond_s,
    input logic [3:0] status_o,
    input logic [1:0] vsel_clr_o,
    input logic       boost_off_o
);
    AST_UVLO_ZERO: assert property (@(posedge clk) disable iff (rst)
        uvlo_i |=> (status_o == 4'd0 && vsel_clr_o == 2'd0)); // R1

    AST_SET_ON_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !uvlo_i |=> ((status_o & $past(cond_s)) == $past(cond_s))); // R2

    AST_HOLD_NO_READ: assert property (@(posedge clk) disable iff (rst)
        (!uvlo_i && !rd_stb_i) |=> ((status_o & $past(status_o)) == $past(status_o))); // R3

    AST_READ_KEEPS_PRESENT: assert property (@(posedge clk) disable iff (rst)
        (!uvlo_i && rd_stb_i) |=>
            ((status_o & $past(status_o & cond_s)) == $past(status_o & cond_s))); // R4

    AST_BOOST_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        boost_off_o |-> status_o[0]); // R6

    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (vsel_clr_o != 2'd0) |=> (vsel_clr_o == 2'd0)); // R7

    AST_CLR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        vsel_clr_o[0] |-> (status_o[0] || status_o[1])); // R8
endmodule

bind fault_recovery_mgr fault_recovery_mgr_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .uvlo_i      (uvlo_i),
    .rd_stb_i    (rd_stb_i),
    .cond_s      (cond_s),
    .status_o    (status_o),
    .vsel_clr_o  (vsel_clr_o),
    .boost_off_o (boost_off_o)
);

// File: tb/tb_fault_recovery_mgr.sv
module tb_fault_recovery_mgr;
    localparam int SYNC = 2;
    localparam int LAT  = SYNC + 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       uvlo_i = 1'b0;
    logic       rd_stb_i = 1'b0;
    logic       hot_i = 1'b0, ovl_a_i = 1'b0, ovl_b_i = 1'b0, png_i = 1'b0;
    logic       therm_wipe_i = 1'b0, ovl_wipe_i = 1'b0;
    logic [3:0] status_o;
    logic       fault_n_o;
    logic [1:0] vsel_clr_o;
    logic       boost_off_o;
    logic [1:0] chan_off_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    fault_recovery_mgr #(.SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst(rst), .uvlo_i(uvlo_i), .rd_stb_i(rd_stb_i),
        .hot_i(hot_i), .ovl_a_i(ovl_a_i), .ovl_b_i(ovl_b_i), .png_i(png_i),
        .therm_wipe_i(therm_wipe_i), .ovl_wipe_i(ovl_wipe_i),
        .status_o(status_o), .fault_n_o(fault_n_o), .vsel_clr_o(vsel_clr_o),
        .boost_off_o(boost_off_o), .chan_off_o(chan_off_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic [3:0] p);
        hot_i   = p[0];
        ovl_a_i = p[1];
        ovl_b_i = p[2];
        png_i   = p[3];
    endtask

    task automatic do_read();
        rd_stb_i = 1'b1;
        step(1);
        rd_stb_i = 1'b0;
    endtask

    function automatic logic [1:0] exp_clr(input logic [3:0] on, input logic tw, input logic ow);
        return {(tw & on[0]) | (ow & on[2]), (tw & on[0]) | (ow & on[1])};
    endfunction

    function automatic logic [1:0] exp_off(input logic [3:0] p);
        return {p[0] | p[2], p[0] | p[1]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        chk(status_o == 4'd0, "R1 reset status", status_o, 0);
        chk(fault_n_o == 1'b1, "R1 reset fault pin", fault_n_o, 1);
        chk(vsel_clr_o == 2'd0 && chan_off_o == 2'd0 && boost_off_o == 1'b0,
            "R1 reset outputs", {vsel_clr_o, chan_off_o, boost_off_o}, 0);

        for (int pol = 0; pol < 4; pol++) begin
            therm_wipe_i = pol[0];
            ovl_wipe_i   = pol[1];
            for (int s = 1; s < 16; s++) begin
                for (int k = 0; k < 16; k++) begin
                    logic [3:0] sp;
                    logic [3:0] kp;
                    sp = 4'(s);
                    kp = 4'(s) & 4'(k);
                    drive(sp);
                    step(LAT);
                    chk(status_o == sp, "R2 set after latency", status_o, sp);
                    chk(fault_n_o == 1'b0, "R5 fault pin low", fault_n_o, 0);
                    chk(vsel_clr_o == exp_clr(sp, therm_wipe_i, ovl_wipe_i),
                        "R7 R8 clear request", vsel_clr_o, exp_clr(sp, therm_wipe_i, ovl_wipe_i));
                    chk(boost_off_o == sp[0] && chan_off_o == exp_off(sp),
                        "R6 shutdown on", {boost_off_o, chan_off_o}, {sp[0], exp_off(sp)});
                    step(1);
                    chk(vsel_clr_o == 2'd0, "R7 single cycle pulse", vsel_clr_o, 0);
                    do_read();
                    chk(status_o == sp, "R4 read while present", status_o, sp);
                    drive(kp);
                    step(SYNC);
                    chk(status_o == sp, "R3 held without read", status_o, sp);
                    do_read();
                    chk(status_o == kp, "R4 read after removal", status_o, kp);
                    chk(fault_n_o == (kp == 4'd0), "R5 fault pin", fault_n_o, kp == 4'd0);
                    chk(boost_off_o == kp[0] && chan_off_o == exp_off(kp),
                        "R6 automatic release", {boost_off_o, chan_off_o}, {kp[0], exp_off(kp)});
                    chk(vsel_clr_o == 2'd0, "R8 no request on removal", vsel_clr_o, 0);
                    drive(4'd0);
                    step(SYNC);
                    do_read();
                    chk(status_o == 4'd0 && fault_n_o == 1'b1, "R4 all cleared",
                        {fault_n_o, status_o}, 5'h10);
                    step(1);
                end
            end
        end

        // lockout with fault onset and full wipe policy
        therm_wipe_i = 1'b1;
        ovl_wipe_i   = 1'b1;
        uvlo_i = 1'b1;
        drive(4'hF);
        for (int c = 0; c < LAT + 1; c++) begin
            step(1);
            chk(vsel_clr_o == 2'd0, "R9 no request in lockout", vsel_clr_o, 0);
            chk(status_o == 4'd0 && fault_n_o == 1'b1, "R1 lockout zeroes",
                {fault_n_o, status_o}, 5'h10);
            chk(boost_off_o == 1'b0 && chan_off_o == 2'd0, "R1 lockout shutdown low",
                {boost_off_o, chan_off_o}, 0);
        end
        uvlo_i = 1'b0;
        step(1);
        chk(status_o == 4'hF, "R9 resets after release", status_o, 4'hF);
        chk(vsel_clr_o == 2'd0, "R9 no request on release", vsel_clr_o, 0);
        drive(4'd0);
        step(LAT);
        chk(status_o == 4'hF, "R3 latched before lockout", status_o, 4'hF);
        uvlo_i = 1'b1;
        step(1);
        chk(status_o == 4'd0 && fault_n_o == 1'b1, "R1 lockout clears latched",
            {fault_n_o, status_o}, 5'h10);
        uvlo_i = 1'b0;
        step(2);
        chk(status_o == 4'd0, "R1 stays clear after lockout", status_o, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule